// File: doc/BRIEF.md
# Serial Codec Frame Port

This block is the serial side of a port that either passes a UART's transmit and request-to-send lines straight through, or works as a synchronous codec link. In codec mode it moves 8-bit or 16-bit samples, or back-to-back 16-bit slots in the link mode, on an external bit clock. Each frame starts at a rising edge of a frame-sync input. Transmit words come from a small transmit FIFO and received words go into a receive FIFO. The bit clock and frame sync are oversampled on the system clock, so all state lives in one clock domain.

A single 8-bit control register holds the mode, the bit order, and a one-bit-clock first-slot delay. It also holds a warm-reset bit that pins the frame-sync output high, an active-low cold-reset output for the codec, and a two-bit field that routes two DMA request lines. The request sources are the FIFO levels, this port's combined request, and the peer UART's interrupt. Writing UART mode while a codec mode is active returns the whole port to its reset state.

Top module: `codec_frame_port`

## Requirements
- R1: After reset the control register reads 0x80, the cold-reset output is high, both FIFOs are empty, and the port is in UART mode.
- R2: Register bits [6:5] select the mode (00 UART, 01 8-bit codec, 10 16-bit codec, 11 link mode). In UART mode `sdout` follows `uart_txd`, and `fs_out` follows `uart_rts` unless warm reset is set.
- R3: A write with bits [6:5] = 00 while the port is in a codec mode restores the register to 0x80 and empties both FIFOs. The same write made while already in UART mode is stored as written.
- R4: With bit 3 = 0, the first data bit goes out on the bit-clock rising edge at which the frame-sync rise is seen. With bit 3 = 1, it goes out one bit-clock later, and `sdout` is 0 on the edge in between.
- R5: In the 8-bit and 16-bit modes, bit 4 = 0 sends and receives MSB first, and bit 4 = 1 sends and receives LSB first.
- R6: Mode 01 moves the low 8 bits of each transmit word and zero-extends received samples to 16 bits. Mode 10 moves 16 bits. Both modes move one slot per frame and leave `sdout` at 0 after it.
- R7: Mode 11 runs 16-bit slots back to back until the next frame-sync rise, popping one transmit word per slot. It always sends MSB first, whatever bit 4 says.
- R8: `sdin` is sampled on bit-clock falling edges. Each completed word enters the receive FIFO in arrival order, and transmit words are sent in the order they were pushed.
- R9: While bit 2 (warm reset) is 1, `fs_out` is 1.
- R10: `codec_rst_n` equals bit 7, so writing 0 there asserts the codec cold reset.
- R11: `dreq2` carries `peer_irq` when bit 0 is 0, and the receive request when bit 0 is 1.
- R12: `dreq3` carries the transmit request (transmit FIFO empty) when bits [1:0] = 01. Otherwise it carries the combined request: in a codec mode the OR of the transmit and receive requests, and in UART mode `uart_irq`.
- R13: The receive request means "receive FIFO full" when `rx_req_avail` is 0, and "receive FIFO not empty" when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tx_push | input | 1 | Push a word into the transmit FIFO |
| tx_wdata | input | 16 | Transmit word |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Remove the head word of the receive FIFO |
| rx_rdata | output | 16 | Receive FIFO head word |
| rx_empty | output | 1 | Receive FIFO empty |
| bclk | input | 1 | Serial bit clock |
| fs_in | input | 1 | Frame-sync input |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| fs_out | output | 1 | Frame sync / request-to-send output |
| codec_rst_n | output | 1 | Codec cold reset, active low |
| uart_txd | input | 1 | UART transmit data for pass-through |
| uart_rts | input | 1 | UART request-to-send for pass-through |
| uart_irq | input | 1 | This UART's combined interrupt |
| peer_irq | input | 1 | Other UART's combined interrupt |
| rx_req_avail | input | 1 | Receive request on not-empty instead of full |
| dreq2 | output | 1 | DMA request line 2 |
| dreq3 | output | 1 | DMA request line 3 |

## Verification
A wrong slot counter or bit-position decode shows up on `sdout` within the current frame, as a misplaced, reversed or truncated serial word. It also shows up in the receive FIFO head word one bit-clock fall after the last bit. A mistake in the start logic shifts every bit by one bit-clock, which the sample taken on the first edge after the frame-sync rise exposes at once. Errors in the clear path or the request routing appear on `reg_rdata`, `tx_full`, `rx_empty` and the two request lines one system clock after the write or the FIFO change.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    typedef enum logic [1:0] {
        MODE_UART = 2'b00,
        MODE_C8   = 2'b01,
        MODE_C16  = 2'b10,
        MODE_LINK = 2'b11
    } mode_e;

    typedef struct packed {
        logic       cold_n;
        mode_e      mode;
        logic       lsb_first;
        logic       delay1;
        logic       warm;
        logic [1:0] dreq_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(8'h80);

endpackage

// File: rtl/cfp_ctrl_reg.sv
module cfp_ctrl_reg
    import cfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output ctrl_t      ctrl_o,
    output logic       clear_o
);

    ctrl_t ctrl_d, ctrl_q;
    ctrl_t wr_val;

    always_comb begin
        wr_val  = ctrl_t'(wdata_i);
        ctrl_d  = ctrl_q;
        clear_o = wr_i && (wr_val.mode == MODE_UART) && (ctrl_q.mode != MODE_UART);
        if (clear_o) begin
            ctrl_d = CTRL_RESET;
        end else if (wr_i) begin
            ctrl_d = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    assert_clear_restores_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (ctrl_o == CTRL_RESET));

endmodule

// File: rtl/cfp_fifo.sv
module cfp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] data_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d   = ptr_q;
        mem_d   = mem_q;
        empty_o = (ptr_q.cnt == '0);
        full_o  = (ptr_q.cnt == CW'(DEPTH));
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (flush_i) begin
            ptr_d = '0;
        end else begin
            if (do_push) begin
                mem_d[ptr_q.wr] = data_i;
                ptr_d.wr        = wrap_inc(ptr_q.wr);
            end
            if (do_pop) ptr_d.rd = wrap_inc(ptr_q.rd);
            if (do_push && !do_pop) ptr_d.cnt = ptr_q.cnt + 1'b1;
            if (do_pop && !do_push) ptr_d.cnt = ptr_q.cnt - 1'b1;
        end
        data_o = mem_q[ptr_q.rd];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

    assert_push_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i && !flush_i) |=> !empty_o);

endmodule

// File: rtl/cfp_shifter.sv
module cfp_shifter
    import cfp_pkg::*;
#(
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  mode_e            mode_i,
    input  logic             lsb_i,
    input  logic             delay_i,
    input  logic             bclk_i,
    input  logic             fs_i,
    input  logic             sd_i,
    input  logic [MAX_W-1:0] tx_word_i,
    input  logic             tx_avail_i,
    output logic             tx_pop_o,
    output logic             rx_push_o,
    output logic [MAX_W-1:0] rx_word_o,
    output logic             sd_o
);

    localparam int IW     = $clog2(MAX_W);
    localparam int NARROW = MAX_W / 2;

    typedef struct packed {
        logic             b1;
        logic             b2;
        logic             fs_s;
        logic             fs_last;
        logic             active;
        logic             pend;
        logic             txd;
        logic [IW-1:0]    idx;
        logic [MAX_W-1:0] word;
        logic [MAX_W-1:0] acc;
    } sh_t;

    sh_t s_d, s_q;
    logic rise, fall, fs_rise, codec, lsb_eff, start;
    logic [IW-1:0] last_idx, idx_nx;

    function automatic logic [IW-1:0] bit_pos(input logic lsb, input logic [IW-1:0] last,
                                              input logic [IW-1:0] i);
        return lsb ? i : last - i;
    endfunction

    always_comb begin
        codec    = (mode_i != MODE_UART);
        lsb_eff  = lsb_i && (mode_i != MODE_LINK);
        last_idx = (mode_i == MODE_C8) ? IW'(NARROW - 1) : IW'(MAX_W - 1);
        rise     = s_q.b1 && !s_q.b2;
        fall     = !s_q.b1 && s_q.b2;
        fs_rise  = s_q.fs_s && !s_q.fs_last;
        idx_nx   = s_q.idx + 1'b1;
        start    = 1'b0;
        tx_pop_o = 1'b0;
        rx_push_o = 1'b0;

        s_d      = s_q;
        s_d.b1   = bclk_i;
        s_d.b2   = s_q.b1;
        s_d.fs_s = fs_i;
        if (rise) s_d.fs_last = s_q.fs_s;

        if (clear_i || !codec) begin
            s_d.active = 1'b0;
            s_d.pend   = 1'b0;
            s_d.txd    = 1'b0;
            s_d.idx    = '0;
            s_d.acc    = '0;
        end else if (rise) begin
            if (fs_rise) begin
                if (delay_i) begin
                    s_d.pend   = 1'b1;
                    s_d.active = 1'b0;
                    s_d.txd    = 1'b0;
                end else begin
                    start = 1'b1;
                end
            end else if (s_q.pend) begin
                s_d.pend = 1'b0;
                start    = 1'b1;
            end else if (s_q.active) begin
                if (s_q.idx == last_idx) begin
                    if (mode_i == MODE_LINK) begin
                        start = 1'b1;
                    end else begin
                        s_d.active = 1'b0;
                        s_d.txd    = 1'b0;
                    end
                end else begin
                    s_d.idx = idx_nx;
                    s_d.txd = s_q.word[bit_pos(lsb_eff, last_idx, idx_nx)];
                end
            end
            if (start) begin
                s_d.active = 1'b1;
                s_d.idx    = '0;
                s_d.acc    = '0;
                s_d.word   = tx_avail_i ? tx_word_i : '0;
                tx_pop_o   = tx_avail_i;
                s_d.txd    = s_d.word[bit_pos(lsb_eff, last_idx, '0)];
            end
        end else if (fall && s_q.active) begin
            s_d.acc[bit_pos(lsb_eff, last_idx, s_q.idx)] = sd_i;
            rx_push_o = (s_q.idx == last_idx);
        end
        rx_word_o = s_d.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sd_o = s_q.txd;

    assert_txd_only_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !clear_i) |=> $stable(sd_o));

    assert_push_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |-> (s_q.b2 && !s_q.b1));

endmodule

// File: rtl/codec_frame_port.sv
module codec_frame_port
    import cfp_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                tx_push,
    input  logic [SAMPLE_W-1:0] tx_wdata,
    output logic                tx_full,
    input  logic                rx_pop,
    output logic [SAMPLE_W-1:0] rx_rdata,
    output logic                rx_empty,
    input  logic                bclk,
    input  logic                fs_in,
    input  logic                sdin,
    output logic                sdout,
    output logic                fs_out,
    output logic                codec_rst_n,
    input  logic                uart_txd,
    input  logic                uart_rts,
    input  logic                uart_irq,
    input  logic                peer_irq,
    input  logic                rx_req_avail,
    output logic                dreq2,
    output logic                dreq3
);

    ctrl_t ctrl;
    logic clear, codec;
    logic tx_empty, tx_pop, rx_push, rx_full, sh_out;
    logic tx_req, rx_req, own_irq;
    logic [SAMPLE_W-1:0] tx_head, rx_word;

    cfp_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (reg_wr),
        .wdata_i(reg_wdata),
        .ctrl_o (ctrl),
        .clear_o(clear)
    );

    cfp_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(clear),
        .push_i (tx_push),
        .data_i (tx_wdata),
        .pop_i  (tx_pop),
        .data_o (tx_head),
        .empty_o(tx_empty),
        .full_o (tx_full)
    );

    cfp_fifo #(.WIDTH(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(clear),
        .push_i (rx_push),
        .data_i (rx_word),
        .pop_i  (rx_pop),
        .data_o (rx_rdata),
        .empty_o(rx_empty),
        .full_o (rx_full)
    );

    cfp_shifter #(.MAX_W(SAMPLE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .mode_i    (ctrl.mode),
        .lsb_i     (ctrl.lsb_first),
        .delay_i   (ctrl.delay1),
        .bclk_i    (bclk),
        .fs_i      (fs_in),
        .sd_i      (sdin),
        .tx_word_i (tx_head),
        .tx_avail_i(!tx_empty),
        .tx_pop_o  (tx_pop),
        .rx_push_o (rx_push),
        .rx_word_o (rx_word),
        .sd_o      (sh_out)
    );

    always_comb begin
        codec       = (ctrl.mode != MODE_UART);
        reg_rdata   = ctrl;
        codec_rst_n = ctrl.cold_n;
        sdout       = codec ? sh_out : uart_txd;
        fs_out      = ctrl.warm ? 1'b1 : (codec ? fs_in : uart_rts);
        tx_req      = codec && tx_empty;
        rx_req      = codec && (rx_req_avail ? !rx_empty : rx_full);
        own_irq     = codec ? (tx_req || rx_req) : uart_irq;
        dreq2       = ctrl.dreq_sel[0] ? rx_req : peer_irq;
        dreq3       = (ctrl.dreq_sel == 2'b01) ? tx_req : own_irq;
    end

    assert_warm_forces_fs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.warm |-> fs_out);

    assert_dreq3_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (codec && ctrl.dreq_sel == 2'b01) |-> (dreq3 == tx_empty));

    assert_cold_follows_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (codec_rst_n == $past(reg_wdata[7]) || $past(clear)));

endmodule

// File: tb/sim_codec_frame_port.sv
module sim_codec_frame_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, tx_push = 0, rx_pop = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic [15:0] tx_wdata = 0, rx_rdata;
    logic tx_full, rx_empty, sdout, fs_out, codec_rst_n, dreq2, dreq3;
    logic bclk = 0, fs_in = 0, sdin = 0;
    logic uart_txd = 0, uart_rts = 0, uart_irq = 0, peer_irq = 0, rx_req_avail = 0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    codec_frame_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_empty(rx_empty), .bclk(bclk), .fs_in(fs_in), .sdin(sdin),
        .sdout(sdout), .fs_out(fs_out), .codec_rst_n(codec_rst_n), .uart_txd(uart_txd),
        .uart_rts(uart_rts), .uart_irq(uart_irq), .peer_irq(peer_irq),
        .rx_req_avail(rx_req_avail), .dreq2(dreq2), .dreq3(dreq3)
    );

    // mode, lsb bit, delay bit, transmit word, receive word
    localparam logic [35:0] VEC [6] = '{
        {2'd1, 1'b0, 1'b0, 16'h00A5, 16'h003C},
        {2'd1, 1'b1, 1'b0, 16'h00A5, 16'h003C},
        {2'd1, 1'b0, 1'b1, 16'h00D2, 16'h00C3},
        {2'd2, 1'b0, 1'b0, 16'h1234, 16'hBEEF},
        {2'd2, 1'b1, 1'b1, 16'h8001, 16'h0F0F},
        {2'd3, 1'b1, 1'b0, 16'hC0DE, 16'h9876}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic push_tx(input logic [15:0] v);
        @(negedge clk); tx_push = 1; tx_wdata = v;
        @(negedge clk); tx_push = 0;
    endtask

    task automatic pop_rx;
        @(negedge clk); rx_pop = 1;
        @(negedge clk); rx_pop = 0;
    endtask

    task automatic tick(input bit fs, input bit rb, output bit s);
        @(negedge clk); fs_in = fs; sdin = rb;
        repeat (4) @(negedge clk);
        bclk = 1;
        repeat (4) @(negedge clk);
        s = sdout;
        bclk = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input int w, input bit lsb, input bit dly, input int nslots,
                             input logic [15:0] rx0, input logic [15:0] rx1,
                             output logic [15:0] tx0, output logic [15:0] tx1, output bit first);
        tx0 = 0; tx1 = 0; first = 0;
        for (int t = 0; t < int'(dly) + w * nslots; t++) begin
            int k, sl, p;
            bit rb, s;
            k = t - int'(dly); rb = 0; sl = 0; p = 0;
            if (k >= 0) begin
                sl = k / w;
                p  = lsb ? (k % w) : (w - 1 - (k % w));
                rb = (sl == 0) ? rx0[p] : rx1[p];
            end
            tick(t == 0, rb, s);
            if (t == 0) first = s;
            if (k >= 0) begin
                if (sl == 0) tx0[p] = s; else tx1[p] = s;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] t0, t1, m;
        bit fb, s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(reg_rdata == 8'h80, "R1 reg", reg_rdata, 8'h80);
        check(codec_rst_n == 1 && rx_empty == 1 && tx_full == 0, "R1 outputs",
              {codec_rst_n, rx_empty, tx_full}, 3'b110);
        uart_txd = 1; @(negedge clk);
        check(sdout == 1, "R2 uart pass", sdout, 1);

        // vector table: modes, orders, delays
        for (int i = 0; i < 6; i++) begin
            logic [1:0] md;
            bit lsb, dly, le;
            int w;
            md  = VEC[i][35:34]; lsb = VEC[i][33]; dly = VEC[i][32];
            w   = (md == 2'd1) ? 8 : 16;
            le  = lsb && (md != 2'd3);
            m   = (w == 8) ? 16'h00FF : 16'hFFFF;
            wr_reg({1'b1, md, lsb, dly, 3'b000});
            push_tx(VEC[i][31:16]);
            run_frame(w, le, dly, 1, VEC[i][15:0], 16'h0, t0, t1, fb);
            check(t0 == (VEC[i][31:16] & m), "R5 R6 R7 tx word", t0, VEC[i][31:16] & m);
            if (dly) check(fb == 0, "R4 delayed start", fb, 0);
            else     check(fb == (le ? VEC[i][16] : VEC[i][16 + w - 1]), "R4 immediate start", fb, 1);
            repeat (2) @(negedge clk);
            check(rx_empty == 0 && rx_rdata == (VEC[i][15:0] & m), "R8 rx word",
                  rx_rdata, VEC[i][15:0] & m);
            pop_rx();
        end

        // R7 link mode back-to-back slots, lsb bit ignored
        wr_reg(8'hF0);
        push_tx(16'hBEEF); push_tx(16'h1234);
        run_frame(16, 0, 0, 2, 16'hCAFE, 16'h5A5A, t0, t1, fb);
        check(t0 == 16'hBEEF, "R7 slot0 tx", t0, 16'hBEEF);
        check(t1 == 16'h1234, "R7 slot1 tx", t1, 16'h1234);
        repeat (2) @(negedge clk);
        check(rx_rdata == 16'hCAFE, "R7 slot0 rx", rx_rdata, 16'hCAFE);
        pop_rx();
        check(rx_rdata == 16'h5A5A && !rx_empty, "R8 order rx", rx_rdata, 16'h5A5A);
        pop_rx();

        // request routing in 8-bit mode, FIFOs empty
        wr_reg(8'hA0);
        peer_irq = 1; @(negedge clk);
        check(dreq2 == 1, "R11 peer routed", dreq2, 1);
        peer_irq = 0; @(negedge clk);
        check(dreq2 == 0, "R11 peer low", dreq2, 0);
        check(dreq3 == 1, "R12 combined tx-empty", dreq3, 1);
        wr_reg(8'hA1);
        check(dreq3 == 1 && dreq2 == 0, "R12 R11 sel01", {dreq3, dreq2}, 2'b10);
        push_tx(16'h00AA); push_tx(16'h00FF);
        check(dreq3 == 0, "R12 tx not empty", dreq3, 0);
        run_frame(8, 0, 0, 1, 16'h0011, 16'h0, t0, t1, fb);
        // R6 one slot only: next word 0xFF waits, sdout stays 0
        tick(0, 1, s);
        check(s == 0, "R6 single slot idle", s, 0);
        tick(0, 1, s);
        check(s == 0, "R6 single slot idle2", s, 0);
        check(dreq2 == 0, "R13 full mode not full", dreq2, 0);
        rx_req_avail = 1; @(negedge clk);
        check(dreq2 == 1, "R13 not-empty mode", dreq2, 1);
        wr_reg(8'hA3);
        check(dreq2 == 1 && dreq3 == 1, "R11 R12 sel11", {dreq2, dreq3}, 2'b11);
        wr_reg(8'hA2);
        check(dreq2 == 0 && dreq3 == 1, "R11 R12 sel10", {dreq2, dreq3}, 2'b01);
        rx_req_avail = 0;
        wr_reg(8'hA1);
        for (int f = 0; f < 3; f++) run_frame(8, 0, 0, 1, 16'h0022, 16'h0, t0, t1, fb);
        repeat (2) @(negedge clk);
        check(dreq2 == 1, "R13 rx full", dreq2, 1);

        // R3 flush on return to UART
        for (int f = 0; f < 4; f++) push_tx(16'h0101);
        check(tx_full == 1, "R3 tx filled", tx_full, 1);
        wr_reg(8'h00);
        check(reg_rdata == 8'h80, "R3 reg restored", reg_rdata, 8'h80);
        check(tx_full == 0 && rx_empty == 1, "R3 fifos flushed", {tx_full, rx_empty}, 2'b01);

        // R9 warm, R2 rts pass, R10 cold, R3 no clear from UART
        uart_rts = 0;
        wr_reg(8'h84);
        check(fs_out == 1, "R9 warm forces", fs_out, 1);
        wr_reg(8'h80);
        uart_rts = 1; @(negedge clk);
        check(fs_out == 1, "R2 rts pass high", fs_out, 1);
        uart_rts = 0; @(negedge clk);
        check(fs_out == 0, "R2 rts pass low", fs_out, 0);
        wr_reg(8'h00);
        check(codec_rst_n == 0, "R10 cold asserted", codec_rst_n, 0);
        check(reg_rdata == 8'h00, "R3 uart write kept", reg_rdata, 0);
        wr_reg(8'h80);
        check(codec_rst_n == 1, "R10 cold released", codec_rst_n, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule